// File: doc/BRIEF.md
# Receive Result Queue with Pop Register

This block buffers conversion results that arrive from a converter-side interface in a small circular queue of four entries. A host on a simple register bus takes results out by reading a pop register. Each such read returns the oldest result and removes it. The host can also read any slot directly at its own word address, which changes nothing. A combined status and control register shows the occupancy count, the pop pointer and a sticky overflow flag, and it holds the enable bit for the service request.

The queue keeps only a pop pointer and an occupancy counter. The write slot is always the pop pointer plus the count, wrapped to the depth. A result that arrives while the queue is full is dropped and sets the overflow flag; the stored data is left as it was. A service request line, meant for an interrupt controller or a DMA engine, goes high while results are waiting and the request is enabled. It is held until a DMA-done pulse arrives after the queue has drained.

Bus reads return data on `bus_rdata`, with `bus_rvalid` high, in the cycle after the read strobe. Pushes and pops take effect at the same clock edge.

Top module: `rxres_fifo`

## Requirements
- R1: After a synchronous reset, the count, pop pointer, overflow flag, request enable, `req`, `bus_rvalid` and `bus_rdata` are all zero.
- R2: A result pushed while the queue is not full is stored in slot (pop pointer + count) mod 4, and the count rises by one.
- R3: A result pushed while the queue is full and no pop is accepted in that cycle sets the overflow flag and is discarded. The stored entries, the count and the pop pointer do not change.
- R4: A read of the pop register (byte address 0x00) on a non-empty queue returns the entry at the pop pointer, zero-extended, one cycle later. The count drops by one, and the pointer advances modulo 4.
- R5: A read of the pop register on an empty queue returns zero and changes neither the count nor the pop pointer.
- R6: A read of byte address 0x10 + 4*k (k = 0..3) returns slot k, zero-extended, and changes no state.
- R7: A read of the status register (byte address 0x04) returns the count in bits [2:0], the pop pointer in bits [5:4], the overflow flag in bit 8 and the request enable in bit 16, with all other bits zero. A read of any unmapped address returns zero.
- R8: A push and an accepted pop in the same cycle leave the count unchanged and advance the pointer. The new result goes to the write slot as it stood before the pop. On a full queue the push is accepted.
- R9: Writing the status register with bit 8 set clears the overflow flag. If an overflowing push happens in the same cycle as the clear, the flag stays set. Bit 16 of every status write is loaded into the request enable.
- R10: `req` is set in the cycle after one in which the count is nonzero and the enable is set. It then stays high until a cycle in which `dma_done` is high and that set condition does not hold, and it is low in the cycle after that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | A conversion result is offered this cycle |
| res_data | input | 16 | Conversion result |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 8 | Byte address of the bus access |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after `bus_rd` |
| bus_rvalid | output | 1 | Marks `bus_rdata` as valid |
| dma_done | input | 1 | DMA-done pulse, releases the request once the queue is empty |
| req | output | 1 | Interrupt or DMA service request |

## Verification
Directed sequences come first. They fill the queue to four and push once more, which separates correct dropping from overwriting. They read every window slot, pop the full queue while pushing, race a flag clear against an overflow, and pop an empty queue. Each of these cases tells a wrap or full/empty fault apart from correct counting. A seeded random phase follows. It mixes pushes, pop reads, window and status reads, status writes and DMA-done pulses, so the write index can be checked at every pointer and count combination. Every read is compared with a bench model that tracks the data, the count, the pointer, the flag and the request, and the request line is compared with that model in every cycle.

// File: rtl/rq_pkg.sv
package rq_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_POP  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_WIN  = 2'd3
  } rq_sel_e;

  localparam int unsigned STAT_OVF_BIT = 8;
  localparam int unsigned STAT_EN_BIT  = 16;
  localparam int unsigned STAT_PTR_LSB = 4;
endpackage

// File: rtl/rq_store.sv
module rq_store #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] ra,
  input  logic [PW-1:0] rb,
  output logic [DW-1:0] qa,
  output logic [DW-1:0] qb
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign qa = mem[ra];
  assign qb = mem[rb];
endmodule

// File: rtl/rq_ctrl.sv
module rq_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop_req,
  input  logic          clr_ovf,
  output logic [CW-1:0] cnt,
  output logic [PW-1:0] ptr,
  output logic [PW-1:0] widx,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic          push_ok,
  output logic          pop_ok
);
  logic same_slot;

  assign widx      = ptr + cnt[PW-1:0];
  assign same_slot = (widx == ptr);
  assign full      = same_slot && (cnt != '0);
  assign empty     = same_slot && (cnt == '0);
  assign pop_ok    = pop_req && !empty;
  assign push_ok   = push && (!full || pop_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ptr <= '0;
      ovf <= 1'b0;
    end else begin
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
      if (pop_ok) ptr <= ptr + PW'(1);
      if (push && !push_ok) ovf <= 1'b1;
      else if (clr_ovf)     ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/rq_decode.sv
module rq_decode
  import rq_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned POP_OFS  = 0,
  parameter int unsigned STAT_OFS = 4,
  parameter int unsigned WIN_BASE = 16,
  localparam int unsigned PW      = $clog2(DEPTH)
) (
  input  logic [AW-1:0] addr,
  output rq_sel_e       sel,
  output logic [PW-1:0] win_idx
);
  logic [AW-1:0] woff;

  assign woff    = addr - AW'(WIN_BASE);
  assign win_idx = woff[2 +: PW];

  always_comb begin
    sel = SEL_NONE;
    if (addr == AW'(POP_OFS))                               sel = SEL_POP;
    else if (addr == AW'(STAT_OFS))                         sel = SEL_STAT;
    else if ((addr >= AW'(WIN_BASE)) &&
             (addr <  AW'(WIN_BASE + 4*DEPTH)) &&
             (addr[1:0] == 2'b00))                          sel = SEL_WIN;
  end
endmodule

// File: rtl/rq_req.sv
module rq_req (
  input  logic clk,
  input  logic rst,
  input  logic en_wr,
  input  logic en_val,
  input  logic cnt_nz,
  input  logic dma_done,
  output logic en,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      req <= 1'b0;
    end else begin
      if (en_wr) en <= en_val;
      if (cnt_nz && en)  req <= 1'b1;
      else if (dma_done) req <= 1'b0;
    end
  end
endmodule

// File: rtl/rxres_fifo.sv
module rxres_fifo
  import rq_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned AW       = 8,
  parameter int unsigned BW       = 32,
  parameter int unsigned POP_OFS  = 0,
  parameter int unsigned STAT_OFS = 4,
  parameter int unsigned WIN_BASE = 16,
  localparam int unsigned PW      = $clog2(DEPTH),
  localparam int unsigned CW      = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  output logic          bus_rvalid,
  input  logic          dma_done,
  output logic          req
);
  rq_sel_e       sel;
  logic [PW-1:0] win_idx;
  logic [CW-1:0] cnt;
  logic [PW-1:0] ptr, widx;
  logic          full, empty, ovf, push_ok, pop_ok, en;
  logic          pop_hit, stat_wr;
  logic [DW-1:0] pop_q, win_q;
  logic [BW-1:0] stat_word, rd_mux;

  rq_decode #(.AW(AW), .DEPTH(DEPTH), .POP_OFS(POP_OFS),
              .STAT_OFS(STAT_OFS), .WIN_BASE(WIN_BASE)) u_dec (
    .addr(bus_addr), .sel(sel), .win_idx(win_idx));

  assign pop_hit = bus_rd && (sel == SEL_POP);
  assign stat_wr = bus_wr && (sel == SEL_STAT);

  rq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .push(res_valid), .pop_req(pop_hit),
    .clr_ovf(stat_wr && bus_wdata[STAT_OVF_BIT]),
    .cnt(cnt), .ptr(ptr), .widx(widx), .full(full), .empty(empty),
    .ovf(ovf), .push_ok(push_ok), .pop_ok(pop_ok));

  rq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(push_ok), .waddr(widx), .wdata(res_data),
    .ra(ptr), .rb(win_idx), .qa(pop_q), .qb(win_q));

  rq_req u_req (
    .clk(clk), .rst(rst), .en_wr(stat_wr), .en_val(bus_wdata[STAT_EN_BIT]),
    .cnt_nz(cnt != '0), .dma_done(dma_done), .en(en), .req(req));

  always_comb begin
    stat_word = '0;
    stat_word[CW-1:0]               = cnt;
    stat_word[STAT_PTR_LSB +: PW]   = ptr;
    stat_word[STAT_OVF_BIT]         = ovf;
    stat_word[STAT_EN_BIT]          = en;
  end

  always_comb begin
    case (sel)
      SEL_POP:  rd_mux = pop_ok ? BW'(pop_q) : '0;
      SEL_STAT: rd_mux = stat_word;
      SEL_WIN:  rd_mux = BW'(win_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/rxres_fifo_chk.sv
module rxres_fifo_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned BW    = 32,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = PW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          res_valid,
  input logic          pop_hit,
  input logic          full,
  input logic          empty,
  input logic [CW-1:0] cnt,
  input logic [PW-1:0] ptr,
  input logic          ovf,
  input logic          en,
  input logic          req,
  input logic [BW-1:0] bus_rdata
);
  always_comb begin
    if (!rst) a_r1_cnt_bound: assert (cnt <= CW'(DEPTH));
  end

  a_r2_push_grows: assert property (@(posedge clk) disable iff (rst)
    res_valid && !full && !pop_hit |=> cnt == $past(cnt) + CW'(1));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    res_valid && full && !pop_hit |=> ovf && cnt == $past(cnt) && ptr == $past(ptr));

  a_r4_pop_shrinks: assert property (@(posedge clk) disable iff (rst)
    pop_hit && !empty && !res_valid |=> cnt == $past(cnt) - CW'(1));

  a_r5_empty_pop: assert property (@(posedge clk) disable iff (rst)
    pop_hit && empty && !res_valid |=> bus_rdata == '0 && $stable(cnt) && $stable(ptr));

  a_r8_push_pop: assert property (@(posedge clk) disable iff (rst)
    pop_hit && !empty && res_valid |=> $stable(cnt));

  a_r10_req_set: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) && en |=> req);
endmodule

bind rxres_fifo rxres_fifo_chk #(.DEPTH(DEPTH), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .res_valid(res_valid), .pop_hit(pop_hit),
  .full(full), .empty(empty), .cnt(cnt), .ptr(ptr), .ovf(ovf),
  .en(en), .req(req), .bus_rdata(bus_rdata));

// File: tb/rxres_fifo_bench.sv
module rxres_fifo_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        res_valid = 1'b0;
  logic [15:0] res_data = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, dma_done = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, req;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m [4];
  int cnt = 0, ptr = 0;
  bit ovf = 0, en = 0, mreq = 0;

  always #2 clk = ~clk;

  rxres_fifo u_rxres_fifo (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .dma_done(dma_done), .req(req));

  function automatic logic [31:0] stat_word(int c, int p, bit o, bit e);
    logic [31:0] w = '0;
    w[2:0] = 3'(c);
    w[5:4] = 2'(p);
    w[8]   = o;
    w[16]  = e;
    return w;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(bit p, logic [15:0] d, bit rd, bit wr,
                      logic [7:0] a, logic [31:0] wd, bit dn);
    logic [31:0] exp_rd;
    string tag;
    bit pop_ok, push_ok, clr;
    int old_cnt;
    bit old_en;
    @(negedge clk);
    res_valid = p; res_data = d; bus_rd = rd; bus_wr = wr;
    bus_addr = a; bus_wdata = wd; dma_done = dn;
    @(posedge clk);
    exp_rd = '0; tag = "R7";
    pop_ok = rd && a == 8'h00 && cnt != 0;
    if (rd && a == 8'h00) begin
      tag = (cnt == 0) ? "R5" : (p ? "R8" : "R4");
      if (cnt != 0) exp_rd = {16'h0, m[ptr]};
    end else if (rd && a == 8'h04) begin
      exp_rd = stat_word(cnt, ptr, ovf, en);
    end else if (rd && a >= 8'h10 && a < 8'h20 && a[1:0] == 2'b00) begin
      tag = "R6"; exp_rd = {16'h0, m[(a - 8'h10) >> 2]};
    end
    push_ok = p && (cnt != 4 || pop_ok);
    if (push_ok) m[(ptr + cnt) % 4] = d;            // R2 write slot
    old_cnt = cnt; old_en = en;
    cnt = cnt + int'(push_ok) - int'(pop_ok);
    if (pop_ok) ptr = (ptr + 1) % 4;
    clr = wr && a == 8'h04 && wd[8];
    if (p && !push_ok) ovf = 1;                      // R3
    else if (clr) ovf = 0;                           // R9
    if (wr && a == 8'h04) en = wd[16];
    if (old_cnt != 0 && old_en) mreq = 1;            // R10
    else if (dn) mreq = 0;
    #1;
    if (rd) begin
      check({tag, " rdata"}, bus_rdata, exp_rd);
      check({tag, " rvalid"}, {31'h0, bus_rvalid}, 32'd1);
    end
    check("R10 req", {31'h0, req}, {31'h0, mreq});
  endtask

  task automatic idle();
    step(0, '0, 0, 0, '0, '0, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 rvalid", {31'h0, bus_rvalid}, 32'h0);
    check("R1 req", {31'h0, req}, 32'h0);
    step(0, '0, 1, 0, 8'h04, '0, 0);                 // R1 status all zero
    // R2 fill, R3 overflow on the fifth push
    for (int i = 0; i < 5; i++) step(1, 16'hA000 + 16'(i), 0, 0, '0, '0, 0);
    step(0, '0, 1, 0, 8'h04, '0, 0);                 // R7 count 4 ovf 1
    for (int k = 0; k < 4; k++) step(0, '0, 1, 0, 8'h10 + 8'(4*k), '0, 0); // R6
    step(0, '0, 1, 0, 8'h08, '0, 0);                 // R7 unmapped
    step(1, 16'hBEEF, 1, 0, 8'h00, '0, 0);           // R8 full push+pop
    step(1, 16'hCAFE, 0, 1, 8'h04, 32'h100, 0);      // R9 set wins over clear
    step(0, '0, 1, 0, 8'h04, '0, 0);
    step(0, '0, 0, 1, 8'h04, 32'h100, 0);            // R9 clear
    step(0, '0, 1, 0, 8'h04, '0, 0);
    step(0, '0, 0, 1, 8'h04, 32'h1_0000, 0);         // R10 enable
    for (int i = 0; i < 6; i++) step(0, '0, 1, 0, 8'h00, '0, 0); // R4, R5
    idle();
    step(0, '0, 1, 0, 8'h04, '0, 0);
    step(0, '0, 0, 0, '0, '0, 1);                    // R10 release
    idle();
    for (int n = 0; n < 4000; n++) begin
      bit p, rd, wr, dn;
      logic [7:0] a;
      logic [31:0] wd;
      p  = ($urandom % 100) < 55;
      rd = ($urandom % 100) < 45;
      wr = ($urandom % 100) < 8;
      dn = ($urandom % 100) < 10;
      case ($urandom % 8)
        0, 1, 2: a = 8'h00;
        3:       a = 8'h04;
        4:       a = 8'h10 + 8'(4 * ($urandom % 4));
        5:       a = 8'h14;
        6:       a = 8'h1C;
        default: a = 8'h24;
      endcase
      if (wr) a = (rd && a != 8'h04) ? a : 8'h04;
      wd = $urandom;
      step(p, 16'($urandom), rd, wr && a == 8'h04, a, wd, dn);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule